// File: doc/BRIEF.md
# Wide Adder Register Harness

This block places a wide combinational adder between registers on every side, so that timing analysis sees only register-to-register paths through the adder, while the chip-level pin count stays small. The two operands are built up one 32-bit word at a time from a narrow input bus, and the registered sum is read back one 32-bit word at a time through a narrow output bus. The carry-in has its own register, and the carry-out has its own output pin.

Every adder variant plugs into the harness through the same port list: two operands, a carry-in, a sum and a carry-out. A parameter picks the variant. One variant is a plain chain adder. The other is a carry-select adder built from bus-width blocks.

A typical sequence has four steps. Send a load strobe once per word, with a select input steering the strobes to operand A or operand B. Latch the carry-in. Pulse the capture strobe once. Then step the word select across the result.

Top module: `addwrap_top`

## Requirements
- R1: After reset, both operands, the carry-in register, the sum register and the carry-out register are zero, so every `rd_word` reads zero and `sum_cout` is 0.
- R2: On a clock edge with `ld_strobe`=1 and `ld_to_b`=0, operand A shifts down by one word. Its new top word is `ld_word`. After DATA_W/BUS_W such strobes, the first word sent is bits [BUS_W-1:0], so words are sent least significant first.
- R3: With `ld_to_b`=1, a load strobe shifts operand B the same way and leaves operand A unchanged. With `ld_to_b`=0, operand B is unchanged.
- R4: On a clock edge with `cin_strobe`=1, the carry-in register takes `cin_bit`. Otherwise it holds its value.
- R5: On a clock edge with `cap_strobe`=1, the sum register takes (A + B + carry-in) mod 2^DATA_W and the carry-out register takes bit DATA_W of that sum. The values used are those held just before the edge.
- R6: Without `cap_strobe`, the sum and carry-out registers hold their values, even when the operands or the carry-in change.
- R7: `rd_word` combinationally shows word `rd_sel` of the sum register, where word i is bits [i*BUS_W+BUS_W-1 : i*BUS_W]. `sum_cout` always shows the carry-out register.
- R8: When a load strobe and the capture strobe fall on the same edge, the capture uses the operand as it was before that shift.
- R9: The carry-select variant gives the same sum and carry-out as the chain variant, including when a carry ripples across every block boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_strobe | input | 1 | Shift one word into the selected operand |
| ld_to_b | input | 1 | 0 targets operand A, 1 targets operand B |
| ld_word | input | BUS_W | Word shifted into the operand |
| cin_strobe | input | 1 | Latch the carry-in |
| cin_bit | input | 1 | Carry-in value |
| cap_strobe | input | 1 | Register sum and carry-out |
| rd_sel | input | SEL_W | Index of the sum word to show |
| rd_word | output | BUS_W | Selected word of the sum register |
| sum_cout | output | 1 | Registered carry-out |

## Verification
The bench builds the harness with DATA_W=128 and BUS_W=32, which gives four words per operand. It also selects the carry-select core. With these values, all-ones operands plus a carry-in send a carry through all four block boundaries, and every word position of the shift and read paths is visited in a few dozen cycles. With four words per operand, a capture that lands on the last load strobe can be told apart from one that lands after all the loads.

// File: rtl/addwrap_pkg.sv
package addwrap_pkg;
  typedef enum logic [0:0] {
    CORE_CHAIN = 1'b0,
    CORE_CSEL  = 1'b1
  } core_style_e;
endpackage

// File: rtl/addwrap_shreg.sv
module addwrap_shreg #(
  parameter int DATA_W = 256,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [BUS_W-1:0]  word_in,
  output logic [DATA_W-1:0] q
);
  generate
    if (DATA_W == BUS_W) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= word_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {word_in, q[DATA_W-1:BUS_W]};
      end
    end
  endgenerate
endmodule

// File: rtl/addwrap_core.sv
module addwrap_core
  import addwrap_pkg::*;
#(
  parameter int          DATA_W = 256,
  parameter int          BLK_W  = 32,
  parameter core_style_e STYLE  = CORE_CHAIN
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);
  localparam int NBLK = DATA_W / BLK_W;

  generate
    if (STYLE == CORE_CHAIN) begin : g_chain
      logic [DATA_W:0] full;
      assign full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
      assign sum  = full[DATA_W-1:0];
      assign cout = full[DATA_W];
    end else begin : g_csel
      logic [NBLK:0] carry;
      assign carry[0] = cin;
      for (genvar i = 0; i < NBLK; i++) begin : g_blk
        logic [BLK_W:0] s_zero;
        logic [BLK_W:0] s_one;
        assign s_zero = {1'b0, a[i*BLK_W +: BLK_W]} + {1'b0, b[i*BLK_W +: BLK_W]};
        assign s_one  = s_zero + {{BLK_W{1'b0}}, 1'b1};
        assign sum[i*BLK_W +: BLK_W] = carry[i] ? s_one[BLK_W-1:0] : s_zero[BLK_W-1:0];
        assign carry[i+1] = carry[i] ? (s_one[BLK_W] | s_zero[BLK_W]) : s_zero[BLK_W];
      end
      assign cout = carry[NBLK];
    end
  endgenerate
endmodule

// File: rtl/addwrap_rdmux.sv
module addwrap_rdmux #(
  parameter int DATA_W = 256,
  parameter int BUS_W  = 32,
  parameter int SEL_W  = 3
) (
  input  logic [DATA_W-1:0] vec,
  input  logic [SEL_W-1:0]  sel,
  output logic [BUS_W-1:0]  word
);
  localparam int WORDS = DATA_W / BUS_W;

  logic [BUS_W-1:0] lanes [WORDS];

  generate
    for (genvar i = 0; i < WORDS; i++) begin : g_lane
      assign lanes[i] = vec[i*BUS_W +: BUS_W];
    end
  endgenerate

  always_comb begin
    word = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (int'(sel) == i) word = lanes[i];
    end
  end
endmodule

// File: rtl/addwrap_top.sv
module addwrap_top
  import addwrap_pkg::*;
#(
  parameter int          DATA_W     = 256,
  parameter int          BUS_W      = 32,
  parameter core_style_e CORE_STYLE = CORE_CHAIN,
  localparam int         WORDS      = DATA_W / BUS_W,
  localparam int         SEL_W      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_strobe,
  input  logic             ld_to_b,
  input  logic [BUS_W-1:0] ld_word,
  input  logic             cin_strobe,
  input  logic             cin_bit,
  input  logic             cap_strobe,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [BUS_W-1:0] rd_word,
  output logic             sum_cout
);
  // named events for the checker
  logic load_a_evt, load_b_evt, cap_evt;
  assign load_a_evt = ld_strobe & ~ld_to_b;
  assign load_b_evt = ld_strobe &  ld_to_b;
  assign cap_evt    = cap_strobe;

  logic [DATA_W-1:0] opa_q, opb_q, sum_d, sum_q;
  logic              cin_q, cout_d, cout_q;

  addwrap_shreg #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_opa (
    .clk(clk), .rst_n(rst_n), .shift_en(load_a_evt), .word_in(ld_word), .q(opa_q)
  );

  addwrap_shreg #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_opb (
    .clk(clk), .rst_n(rst_n), .shift_en(load_b_evt), .word_in(ld_word), .q(opb_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          cin_q <= 1'b0;
    else if (cin_strobe) cin_q <= cin_bit;
  end

  addwrap_core #(.DATA_W(DATA_W), .BLK_W(BUS_W), .STYLE(CORE_STYLE)) u_core (
    .a(opa_q), .b(opb_q), .cin(cin_q), .sum(sum_d), .cout(cout_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else if (cap_evt) begin
      sum_q  <= sum_d;
      cout_q <= cout_d;
    end
  end

  addwrap_rdmux #(.DATA_W(DATA_W), .BUS_W(BUS_W), .SEL_W(SEL_W)) u_rd (
    .vec(sum_q), .sel(rd_sel), .word(rd_word)
  );

  assign sum_cout = cout_q;
endmodule

// File: rtl/addwrap_chk.sv
module addwrap_chk #(
  parameter int DATA_W = 256,
  parameter int BUS_W  = 32,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_a_evt,
  input logic              load_b_evt,
  input logic              cap_evt,
  input logic              cin_strobe,
  input logic              cin_bit,
  input logic [BUS_W-1:0]  ld_word,
  input logic [DATA_W-1:0] opa_q,
  input logic [DATA_W-1:0] opb_q,
  input logic              cin_q,
  input logic [DATA_W-1:0] sum_q,
  input logic              cout_q,
  input logic [SEL_W-1:0]  rd_sel,
  input logic [BUS_W-1:0]  rd_word,
  input logic              sum_cout
);
  function automatic logic [DATA_W:0] ref_add(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] y,
                                              input logic c);
    logic [DATA_W:0] acc;
    logic            cy;
    cy = c;
    for (int i = 0; i < DATA_W; i++) begin
      acc[i] = x[i] ^ y[i] ^ cy;
      cy     = (x[i] & y[i]) | (cy & (x[i] ^ y[i]));
    end
    acc[DATA_W] = cy;
    return acc;
  endfunction

  function automatic logic [BUS_W-1:0] word_of(input logic [DATA_W-1:0] v,
                                               input logic [SEL_W-1:0] idx);
    logic [DATA_W-1:0] sh;
    sh = v >> (int'(idx) * BUS_W);
    return sh[BUS_W-1:0];
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sum_q == '0 && !cout_q && opa_q == '0 && opb_q == '0)); // R1
  AST_A_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    load_a_evt |=> opa_q[DATA_W-1 -: BUS_W] == $past(ld_word)); // R2
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_a_evt |=> $stable(opb_q)); // R3
  AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_b_evt |=> $stable(opa_q)); // R3
  AST_CIN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cin_strobe |=> cin_q == $past(cin_bit)); // R4
  AST_CAPTURE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> {cout_q, sum_q} == ref_add($past(opa_q), $past(opb_q), $past(cin_q))); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> ($stable(sum_q) && $stable(cout_q))); // R6
  AST_READ_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word == word_of(sum_q, rd_sel) && sum_cout == cout_q); // R7
endmodule

bind addwrap_top addwrap_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_a_evt(load_a_evt), .load_b_evt(load_b_evt),
  .cap_evt(cap_evt), .cin_strobe(cin_strobe), .cin_bit(cin_bit), .ld_word(ld_word),
  .opa_q(opa_q), .opb_q(opb_q), .cin_q(cin_q), .sum_q(sum_q), .cout_q(cout_q),
  .rd_sel(rd_sel), .rd_word(rd_word), .sum_cout(sum_cout)
);

// File: tb/sim_addwrap_top.sv
`timescale 1ns/1ps
module sim_addwrap_top;
  import addwrap_pkg::*;
  localparam int DW = 128;
  localparam int BW = 32;
  localparam int NW = DW / BW;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_strobe = 0, ld_to_b = 0, cin_strobe = 0, cin_bit = 0, cap_strobe = 0;
  logic [BW-1:0] ld_word = '0;
  logic [SW-1:0] rd_sel = '0;
  logic [BW-1:0] rd_word;
  logic          sum_cout;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench-side model of the requirements
  logic [DW-1:0] ma = '0, mb = '0, msum = '0;
  logic          mcin = 0, mcout = 0;

  always #2.5 clk = ~clk;

  addwrap_top #(.DATA_W(DW), .BUS_W(BW), .CORE_STYLE(CORE_CSEL)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_strobe(ld_strobe), .ld_to_b(ld_to_b),
    .ld_word(ld_word), .cin_strobe(cin_strobe), .cin_bit(cin_bit),
    .cap_strobe(cap_strobe), .rd_sel(rd_sel), .rd_word(rd_word), .sum_cout(sum_cout)
  );

  task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_model(input string req);
    for (int w = 0; w < NW; w++) begin
      @(negedge clk);
      rd_sel = SW'(w);
      #1;
      chk(req, rd_word, msum[w*BW +: BW]);
    end
    chk({req, " cout"}, {31'd0, sum_cout}, {31'd0, mcout});
  endtask

  task automatic load_op(input bit to_b, input logic [DW-1:0] v);
    for (int w = 0; w < NW; w++) begin
      @(negedge clk);
      ld_strobe = 1; ld_to_b = to_b; ld_word = v[w*BW +: BW];
    end
    @(negedge clk);
    ld_strobe = 0;
    if (to_b) mb = v; else ma = v;
  endtask

  task automatic set_cin(input logic c);
    @(negedge clk);
    cin_strobe = 1; cin_bit = c;
    @(negedge clk);
    cin_strobe = 0; cin_bit = 0;
    mcin = c;
  endtask

  task automatic capture();
    logic [DW:0] full;
    @(negedge clk);
    cap_strobe = 1;
    @(negedge clk);
    cap_strobe = 0;
    full = {1'b0, ma} + {1'b0, mb} + (DW+1)'(mcin);
    msum = full[DW-1:0]; mcout = full[DW];
  endtask

  task automatic t_reset();
    expect_model("R1 reset");
  endtask

  task automatic t_basic();
    load_op(0, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210);
    load_op(1, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
    set_cin(0);
    capture();
    expect_model("R2 R5 R7 basic");
  endtask

  task automatic t_ripple();
    load_op(0, {DW{1'b1}});
    load_op(1, '0);
    set_cin(1);
    capture();
    expect_model("R9 R4 full ripple");
    chk("R9 ripple cout is one", {31'd0, sum_cout}, 32'd1);
  endtask

  task automatic t_edges();
    load_op(0, 128'h0000_0001_ffff_ffff_0000_0000_ffff_ffff);
    load_op(1, 128'hffff_ffff_0000_0000_ffff_ffff_0000_0001);
    set_cin(1);
    capture();
    expect_model("R9 R5 block edges");
  endtask

  task automatic t_hold();
    load_op(0, 128'hdead_beef_0000_1111_2222_3333_4444_5555);
    set_cin(0);
    expect_model("R6 hold without capture");
  endtask

  task automatic t_b_only();
    load_op(1, 128'h0000_0000_0000_0000_0000_0000_0000_0005);
    capture();
    expect_model("R3 B load keeps A");
  endtask

  task automatic t_same_edge();
    logic [DW-1:0] v = 128'haaaa_aaaa_bbbb_bbbb_cccc_cccc_dddd_dddd;
    logic [DW:0]   full;
    for (int w = 0; w < NW; w++) begin
      @(negedge clk);
      ld_strobe = 1; ld_to_b = 0; ld_word = v[w*BW +: BW];
      cap_strobe = (w == NW-1);
      if (w == NW-1) begin
        full = {1'b0, ma} + {1'b0, mb} + (DW+1)'(mcin);
        msum = full[DW-1:0]; mcout = full[DW];
      end
      ma = {v[w*BW +: BW], ma[DW-1:BW]};
    end
    @(negedge clk);
    ld_strobe = 0; cap_strobe = 0;
    expect_model("R8 capture with last load");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_ripple();
    t_edges();
    t_hold();
    t_b_only();
    t_same_edge();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule